// File: doc/BRIEF.md
# Sixteen-bit pipelined instruction decoder

This block is the decode step of a five-stage 16-bit RISC pipeline. Each cycle it looks at one 16-bit instruction word. It drives the two register-file read addresses and takes the two read data words back in the same cycle. From these it builds the control bundle for the later stages.

The bundle holds the ALU command, both ALU operands, the memory write enable and data, and the write-back enable, destination and result select. It is captured into one 57-bit pipeline register at the clock edge after the instruction is presented, and only while decode is enabled.

Branch-if-zero is resolved in this stage. The decoder flags a taken branch combinationally when the tested register reads zero, and it always hands the low six instruction bits to fetch as the branch offset. It also reports which source registers the instruction really reads, for use by an external hazard unit.

Instruction layout:
- Opcode: bits [15:12].
- Destination or store-data register: bits [11:9].
- First source register: bits [8:6].
- Second source register: bits [5:3], or a 6-bit immediate in bits [5:0].

Opcode values: 0000 no-op, 0001 add, 0010 store, 0011 branch-if-zero. Every other value is treated as a no-op.

Pipeline word layout, from the top bit down:

| Bits | Field |
|---|---|
| [56:54] | ALU command (0 = none, 1 = add) |
| [53:38] | ALU operand 1 |
| [37:22] | ALU operand 2 |
| [21] | memory write enable |
| [20:5] | memory write data |
| [4] | write-back enable |
| [3:1] | write-back destination |
| [0] | write-back result select (0 = ALU result) |

Top module: `decode_stage`

## Requirements
- R1: An active-high synchronous reset clears all 57 bits of the pipeline word to zero at the next clock edge.
- R2: Read address A always equals instruction bits [8:6]. Read address B equals bits [11:9] for a store (opcode 0010) and bits [5:3] for every other opcode.
- R3: The branch offset output always equals instruction bits [5:0], whatever the opcode.
- R4: Add (0001) with decode enabled captures the following at the next edge: ALU command 1, operand 1 = read data A, operand 2 = read data B, memory write enable 0, memory write data = read data B, write-back enable 1, result select 0.
- R5: Store (0010) with decode enabled captures the following at the next edge: ALU command 1, operand 1 = read data A, operand 2 = the immediate in bits [5:0] sign-extended to 16 bits, memory write enable 1, memory write data = read data B, write-back enable 0, result select 0.
- R6: Branch-if-zero (0011) raises the branch-taken output combinationally exactly when read data A is zero. With decode enabled it captures: ALU command 0, operand 1 = read data A, operand 2 = the sign-extended immediate, memory write enable 0, memory write data = read data B, write-back enable 0, result select 0.
- R7: Branch-taken stays 0 for every opcode other than 0011, even when read data A is zero.
- R8: No-op (0000) and all unassigned opcodes (0100 to 1111) with decode enabled capture: ALU command 0, memory write enable 0, write-back enable 0, result select 0, operand 1 = read data A, operand 2 = read data B, memory write data = read data B.
- R9: While decode enable is low and reset is low, the pipeline word keeps its value across clock edges.
- R10: Hazard source 1 reports bits [8:6] for add, store and branch-if-zero, and 0 otherwise. Hazard source 2 reports the read address B value for add and store, and 0 otherwise.
- R11: For every captured instruction, the destination field [3:1] equals instruction bits [11:9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dec_en | input | 1 | Decode enable; low holds the pipeline word |
| instr | input | 16 | Instruction word being decoded |
| rd_addr_a | output | 3 | Register file read address A |
| rd_addr_b | output | 3 | Register file read address B |
| rd_data_a | input | 16 | Register file read data A |
| rd_data_b | input | 16 | Register file read data B |
| br_taken | output | 1 | Branch-if-zero condition met |
| br_offset | output | 6 | Branch offset for fetch |
| haz_src_a | output | 3 | Source register 1 in use, else 0 |
| haz_src_b | output | 3 | Source register 2 in use, else 0 |
| pipe_out | output | 57 | Registered control and data bundle |

## Verification
The properties assume that reset is held high from time zero until the first clock edge. They also assume that the read data words are settled by the clock edge, as though the register file answered the addresses within the cycle. The bench drives every input on the falling edge and holds it through the next rising edge, so the captured read data always matches the instruction that was decoded. Reset is raised again mid-stream only at falling edges, which keeps the hold and capture properties inside their disable window.

// File: rtl/decode_stage.sv
module decode_stage #(
  parameter int DW   = 16,
  parameter int IW   = 16,
  parameter int OPW  = 4,
  parameter int RW   = 3,
  parameter int IMMW = 6,
  parameter int CW   = 3,
  localparam int PW  = CW + 2*DW + 1 + DW + 1 + RW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dec_en,
  input  logic [IW-1:0]   instr,
  output logic [RW-1:0]   rd_addr_a,
  output logic [RW-1:0]   rd_addr_b,
  input  logic [DW-1:0]   rd_data_a,
  input  logic [DW-1:0]   rd_data_b,
  output logic            br_taken,
  output logic [IMMW-1:0] br_offset,
  output logic [RW-1:0]   haz_src_a,
  output logic [RW-1:0]   haz_src_b,
  output logic [PW-1:0]   pipe_out
);

  localparam int OP_LO  = IW - OPW;
  localparam int DST_LO = OP_LO - RW;
  localparam int SA_LO  = DST_LO - RW;
  localparam int SB_LO  = IMMW - RW;
  localparam int CMD_LO = PW - CW;

  localparam logic [OPW-1:0] OP_ADD = OPW'(1);
  localparam logic [OPW-1:0] OP_ST  = OPW'(2);
  localparam logic [OPW-1:0] OP_BZ  = OPW'(3);

  localparam logic [CW-1:0] ALU_NONE = '0;
  localparam logic [CW-1:0] ALU_ADD  = CW'(1);

  logic [OPW-1:0] opc;
  logic [RW-1:0]  dst;
  logic           is_add, is_st, is_bz;
  logic           use_imm, mem_we, wb_en;
  logic [CW-1:0]  alu_cmd;
  logic [DW-1:0]  imm_ext, opnd_b;
  logic [PW-1:0]  pipe_d, pipe_q;

  assign opc = instr[IW-1 -: OPW];
  assign dst = instr[DST_LO +: RW];

  always_comb begin
    is_add = 1'b0;
    is_st  = 1'b0;
    is_bz  = 1'b0;
    case (opc)
      OP_ADD:  is_add = 1'b1;
      OP_ST:   is_st  = 1'b1;
      OP_BZ:   is_bz  = 1'b1;
      default: ;
    endcase
  end

  assign use_imm = is_st | is_bz;
  assign mem_we  = is_st;
  assign wb_en   = is_add;
  assign alu_cmd = (is_add | is_st) ? ALU_ADD : ALU_NONE;

  assign rd_addr_a = instr[SA_LO +: RW];
  assign rd_addr_b = is_st ? dst : instr[SB_LO +: RW];

  assign br_offset = instr[IMMW-1:0];
  assign br_taken  = is_bz && (rd_data_a == '0);

  assign haz_src_a = (is_add | is_st | is_bz) ? rd_addr_a : '0;
  assign haz_src_b = (is_add | is_st) ? rd_addr_b : '0;

  assign imm_ext = {{(DW-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
  assign opnd_b  = use_imm ? imm_ext : rd_data_b;

  assign pipe_d = {alu_cmd, rd_data_a, opnd_b, mem_we, rd_data_b, wb_en, dst, 1'b0};

  always_ff @(posedge clk) begin
    if (rst)         pipe_q <= '0;
    else if (dec_en) pipe_q <= pipe_d;
  end

  assign pipe_out = pipe_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !dec_en |=> $stable(pipe_out));

  p_add_ctl_r4: assert property (@(posedge clk) disable iff (rst)
    (dec_en && instr[IW-1 -: OPW] == OP_ADD) |=>
      (pipe_out[4] && pipe_out[PW-1 -: CW] == ALU_ADD && !pipe_out[21]
       && pipe_out[CMD_LO-1 -: DW] == $past(rd_data_a)));

  p_store_ctl_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_en && instr[IW-1 -: OPW] == OP_ST) |=>
      (pipe_out[21] && !pipe_out[4] && pipe_out[PW-1 -: CW] == ALU_ADD));

  p_taken_r6: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (instr[IW-1 -: OPW] == OP_BZ && rd_data_a == '0));

  p_idle_ctl_r8: assert property (@(posedge clk) disable iff (rst)
    (dec_en && instr[IW-1 -: OPW] != OP_ADD && instr[IW-1 -: OPW] != OP_ST
     && instr[IW-1 -: OPW] != OP_BZ) |=>
      (pipe_out[PW-1 -: CW] == '0 && !pipe_out[21] && !pipe_out[4]));

  p_dest_r11: assert property (@(posedge clk) disable iff (rst)
    dec_en |=> pipe_out[3:1] == $past(instr[DST_LO +: RW]));

  p_haz_b_r10: assert property (@(posedge clk) disable iff (rst)
    (haz_src_b != '0) |-> (instr[IW-1 -: OPW] == OP_ADD || instr[IW-1 -: OPW] == OP_ST));

endmodule

// File: tb/decode_stage_tb.sv
`timescale 1ns/1ps
module decode_stage_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dec_en = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] rd_data_a = '0, rd_data_b = '0;
  logic [2:0]  rd_addr_a, rd_addr_b, haz_src_a, haz_src_b;
  logic        br_taken;
  logic [5:0]  br_offset;
  logic [56:0] pipe_out;

  int checks = 0;
  int fails  = 0;
  logic [56:0] exp_q[$];
  string       tag_q[$];
  logic [56:0] model = '0;

  always #4 clk = ~clk;

  decode_stage u_dut (
    .clk(clk), .rst(rst), .dec_en(dec_en), .instr(instr),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .br_taken(br_taken), .br_offset(br_offset),
    .haz_src_a(haz_src_a), .haz_src_b(haz_src_b),
    .pipe_out(pipe_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [3:0] op, input logic [2:0] d,
                                     input logic [2:0] s, input logic [5:0] lo);
    return {op, d, s, lo};
  endfunction

  task automatic step(input logic r, input logic en, input logic [15:0] ins,
                      input logic [15:0] da, input logic [15:0] db);
    logic [3:0]  op;
    logic [15:0] sx;
    logic [2:0]  ab;
    logic        reads;
    string       tg;
    @(negedge clk);
    rst = r; dec_en = en; instr = ins; rd_data_a = da; rd_data_b = db;
    op = ins[15:12];
    sx = {{10{ins[5]}}, ins[5:0]};
    ab = (op == 4'd2) ? ins[11:9] : ins[5:3];
    reads = (op == 4'd1 || op == 4'd2 || op == 4'd3);
    #1;
    chk("R2 addr A", rd_addr_a, ins[8:6]);
    chk("R2 addr B", rd_addr_b, ab);
    chk("R3 offset", br_offset, ins[5:0]);
    chk("R6 R7 taken", br_taken, (op == 4'd3) && (da == 16'd0));
    chk("R10 haz A", haz_src_a, reads ? ins[8:6] : 3'd0);
    chk("R10 haz B", haz_src_b, (op == 4'd1 || op == 4'd2) ? ab : 3'd0);
    if (r) begin
      model = '0; tg = "R1";
    end else if (!en) begin
      tg = "R9";
    end else begin
      case (op)
        4'd1: begin model = {3'd1, da, db, 1'b0, db, 1'b1, ins[11:9], 1'b0}; tg = "R4"; end
        4'd2: begin model = {3'd1, da, sx, 1'b1, db, 1'b0, ins[11:9], 1'b0}; tg = "R5"; end
        4'd3: begin model = {3'd0, da, sx, 1'b0, db, 1'b0, ins[11:9], 1'b0}; tg = "R6"; end
        default: begin model = {3'd0, da, db, 1'b0, db, 1'b0, ins[11:9], 1'b0}; tg = "R8"; end
      endcase
    end
    exp_q.push_back(model);
    tag_q.push_back(tg);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [56:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " pipe word"}, pipe_out, e);
      chk("R11 dest field", pipe_out[3:1], e[3:1]);
    end
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(1, 0, 16'h0000, 16'd0, 16'd0);                        // R1
    step(0, 1, mk(4'd1, 3'd0, 3'd1, 6'b010_000), 16'd31, 16'd28); // R4
    step(0, 1, mk(4'd2, 3'd4, 3'd5, 6'd31), 16'd7, 16'h9a3c);     // R5
    step(0, 1, mk(4'd3, 3'd0, 3'd7, 6'h36), 16'd0, 16'hc32e);     // R6 taken
    step(0, 1, mk(4'd3, 3'd2, 3'd7, 6'h05), 16'd3, 16'h1111);     // R6 not taken
    step(0, 1, mk(4'd0, 3'd5, 3'd3, 6'h2a), 16'h0, 16'h2222);     // R8 R7
    step(0, 1, mk(4'hf, 3'd6, 3'd1, 6'h3f), 16'h0, 16'h3333);     // R8 R7
    step(0, 1, mk(4'd1, 3'd3, 3'd6, 6'b101_000), 16'h0, 16'h4444); // R7 R4
    step(0, 0, mk(4'd2, 3'd7, 3'd1, 6'h01), 16'h5555, 16'h6666);  // R9 hold
    step(0, 0, mk(4'd1, 3'd1, 3'd1, 6'h09), 16'h7777, 16'h8888);  // R9 hold
    step(0, 1, mk(4'd2, 3'd1, 3'd2, 6'h20), 16'habcd, 16'h0f0f);  // R5 negative imm
    step(1, 1, mk(4'd1, 3'd2, 3'd2, 6'h12), 16'h1234, 16'h5678);  // R1 mid-stream
    for (int i = 0; i < 40; i++) begin
      logic [3:0]  op;
      logic [15:0] da;
      op = 4'((i * 7) % 6);
      da = (i % 3 == 0) ? 16'd0 : 16'((i * 977) ^ 16'h5a5a);
      step(0, (i % 5) != 4, mk(op, 3'(i), 3'(i * 3), 6'(i * 11)), da, 16'((i * 313) + 1));
    end
    step(0, 0, 16'h0000, 16'd0, 16'd0);
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule